// File: doc/BRIEF.md
# Configuration Stream Sync-Word Detector

This block sits on the serial data line of a configuration port, where bits arrive from an external serial flash or are pushed in by an external SPI master. Each bit is taken on the rising edge of the serial clock, but only while the port is enabled and chip select is low. Any number of filler bits may come first. The detector slides a window across the stream one bit at a time until the window holds the 16-bit start-of-data pattern 0xBDB3, most significant bit first. The 32 bits that follow immediately form the control word. The block captures that word and takes out the field that selects the new configuration clock rate.

If a number of qualified bits equal to a parameter go by with no start pattern, the block raises a sticky timeout flag so that the boot logic can declare the load failed. Raising chip select restarts that count. Once the start pattern has been seen, the block ignores the rest of the stream until reset, and that includes later copies of the start pattern. All outputs are registered.

Top module: `cfg_preamble_detect`

## Requirements
- R1: While `rst` is high at a rising clock edge, and after that edge, `sync_found`, `ctrl_valid`, `timeout`, `ctrl_word` and `freq_code` are all zero.
- R2: While hunting, the detector compares the last 16 qualified bits, oldest bit as the MSB, against 0xBDB3. `sync_found` goes to 1 at the edge that samples the final bit of the first match, whatever filler came before it.
- R3: A bit is qualified only at a rising edge where `en` is 1 and `cs_n` is 0. A clock edge without qualification leaves the search window, the capture and all outputs unchanged.
- R4: The 32 qualified bits immediately after the match form `ctrl_word`, first bit in bit 31. `ctrl_word` and `ctrl_valid` = 1 appear at the edge that samples the 32nd bit.
- R5: When `ctrl_valid` is 1, `freq_code` equals `ctrl_word[FREQ_LSB+FREQ_W-1:FREQ_LSB]`, which by default is bits 21:16.
- R6: If the hunt takes TIMEOUT_BITS qualified bits without a match, `timeout` goes to 1 at the edge of the last of those bits. A match completed on that same bit counts as found. `timeout` then stays 1, and no later pattern sets `sync_found`.
- R7: Any edge with `cs_n` high restarts the timeout count, so that a full TIMEOUT_BITS qualified hunt bits are needed after it.
- R8: Once `sync_found` is 1, `sync_found` stays 1 and later start patterns are ignored. After `ctrl_valid` is 1, `ctrl_word` and `freq_code` hold until reset.
- R9: After reset the detector hunts afresh, even if reset arrived in the middle of a capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial configuration clock; data is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; qualifies sampling |
| cs_n | input | 1 | Chip select, active low; high restarts the timeout count |
| sdi | input | 1 | Serial data in |
| sync_found | output | 1 | Start-of-data pattern seen (sticky) |
| ctrl_valid | output | 1 | Control word fully captured (sticky) |
| ctrl_word | output | CTRL_W | Captured control word |
| freq_code | output | FREQ_W | Clock-rate field taken from the control word |
| timeout | output | 1 | No start pattern within the allowed bits (sticky) |

## Verification
Several rules hold on every cycle, and the bound checker watches them continuously. Neither `sync_found`, `timeout` nor `ctrl_valid` ever clears outside reset. `timeout` and `sync_found` are never high together. `ctrl_valid` implies `sync_found`. The captured word and the rate field hold once they are valid. A cycle without qualification changes no output. Other behaviour can only be shown by the bench running against its bit-level reference model:
- the exact edge at which a match completes, across different filler lengths and contents;
- the precise bit at which the timeout fires;
- the restart of the count when chip select rises;
- the MSB-first order of the captured word.

// File: rtl/cfg_preamble_pkg.sv
package cfg_preamble_pkg;
  typedef enum logic [1:0] {
    PH_HUNT    = 2'd0,
    PH_CAPTURE = 2'd1,
    PH_DONE    = 2'd2,
    PH_FAIL    = 2'd3
  } phase_t;
endpackage

// File: rtl/cfg_sync_hunter.sv
// Sliding window over the serial stream; flags a match including the bit on the line now.
module cfg_sync_hunter #(
  parameter int              SYNC_W    = 16,
  parameter logic [SYNC_W-1:0] SYNC_WORD = 16'hBDB3
) (
  input  logic clk,
  input  logic rst,
  input  logic shift_en,
  input  logic sdi,
  output logic match
);
  logic [SYNC_W-1:0] window_q;
  logic [SYNC_W-1:0] window_nx;

  assign window_nx = {window_q[SYNC_W-2:0], sdi};
  assign match     = (window_nx == SYNC_WORD);

  always_ff @(posedge clk) begin
    if (rst)
      window_q <= '0;
    else if (shift_en)
      window_q <= window_nx;
  end
endmodule

// File: rtl/cfg_ctrl_capture.sv
// Shifts in the control word MSB first and marks the bit that completes it.
module cfg_ctrl_capture #(
  parameter int CTRL_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              sdi,
  output logic              last_bit,
  output logic [CTRL_W-1:0] word_nx
);
  localparam int CNT_W = $clog2(CTRL_W);

  logic [CTRL_W-1:0] shreg_q;
  logic [CNT_W-1:0]  cnt_q;

  assign word_nx  = {shreg_q[CTRL_W-2:0], sdi};
  assign last_bit = (cnt_q == CNT_W'(CTRL_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (shift_en) begin
      shreg_q <= word_nx;
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_preamble_timer.sv
// Counts qualified hunt bits; the clear input has priority over counting.
module cfg_preamble_timer #(
  parameter int TIMEOUT_BITS = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic count_en,
  output logic expire
);
  localparam int CNT_W = $clog2(TIMEOUT_BITS + 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = count_en && !clear && (cnt_q == CNT_W'(TIMEOUT_BITS - 1));

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt_q <= '0;
    else if (count_en && !expire)
      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_preamble_detect.sv
module cfg_preamble_detect #(
  parameter int                SYNC_W       = 16,
  parameter logic [SYNC_W-1:0] SYNC_WORD    = 16'hBDB3,
  parameter int                CTRL_W       = 32,
  parameter int                FREQ_LSB     = 16,
  parameter int                FREQ_W       = 6,
  parameter int                TIMEOUT_BITS = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sync_found,
  output logic              ctrl_valid,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic [FREQ_W-1:0] freq_code,
  output logic              timeout
);
  import cfg_preamble_pkg::*;

  phase_t            phase_q;
  logic              bit_ok;
  logic              hunt_shift;
  logic              cap_shift;
  logic              match;
  logic              expire;
  logic              last_bit;
  logic [CTRL_W-1:0] word_nx;

  assign bit_ok     = en && !cs_n;
  assign hunt_shift = bit_ok && (phase_q == PH_HUNT);
  assign cap_shift  = bit_ok && (phase_q == PH_CAPTURE);

  cfg_sync_hunter #(
    .SYNC_W    (SYNC_W),
    .SYNC_WORD (SYNC_WORD)
  ) u_hunter (
    .clk      (clk),
    .rst      (rst),
    .shift_en (hunt_shift),
    .sdi      (sdi),
    .match    (match)
  );

  cfg_preamble_timer #(
    .TIMEOUT_BITS (TIMEOUT_BITS)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clear    (cs_n),
    .count_en (hunt_shift),
    .expire   (expire)
  );

  cfg_ctrl_capture #(
    .CTRL_W (CTRL_W)
  ) u_capture (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cap_shift),
    .sdi      (sdi),
    .last_bit (last_bit),
    .word_nx  (word_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_HUNT;
      sync_found <= 1'b0;
      ctrl_valid <= 1'b0;
      ctrl_word  <= '0;
      freq_code  <= '0;
      timeout    <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_HUNT: begin
          if (hunt_shift) begin
            if (match) begin
              phase_q    <= PH_CAPTURE;
              sync_found <= 1'b1;
            end else if (expire) begin
              phase_q <= PH_FAIL;
              timeout <= 1'b1;
            end
          end
        end
        PH_CAPTURE: begin
          if (cap_shift && last_bit) begin
            phase_q    <= PH_DONE;
            ctrl_valid <= 1'b1;
            ctrl_word  <= word_nx;
            freq_code  <= word_nx[FREQ_LSB +: FREQ_W];
          end
        end
        PH_DONE: phase_q <= PH_DONE;
        PH_FAIL: phase_q <= PH_FAIL;
        default: phase_q <= PH_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/cfg_preamble_detect_chk.sv
module cfg_preamble_detect_chk #(
  parameter int CTRL_W   = 32,
  parameter int FREQ_LSB = 16,
  parameter int FREQ_W   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              cs_n,
  input logic              sync_found,
  input logic              ctrl_valid,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic [FREQ_W-1:0] freq_code,
  input logic              timeout
);
  // R8: sync_found never drops outside reset
  p_sync_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    sync_found |=> sync_found);

  // R6: timeout is sticky
  p_timeout_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    timeout |=> timeout);

  // R6: a timed-out hunt never reports a match, and vice versa
  p_fail_excludes_sync_r6: assert property (@(posedge clk) disable iff (rst)
    !(timeout && sync_found));

  // R4: a captured word implies the start pattern was found
  p_word_after_sync_r4: assert property (@(posedge clk) disable iff (rst)
    ctrl_valid |-> sync_found);

  // R8: captured word, field and valid hold once set
  p_word_hold_r8: assert property (@(posedge clk) disable iff (rst)
    ctrl_valid |=> (ctrl_valid && $stable(ctrl_word) && $stable(freq_code)));

  // R5: field agrees with the word it came from
  p_field_match_r5: assert property (@(posedge clk) disable iff (rst)
    ctrl_valid |-> (freq_code == ctrl_word[FREQ_LSB +: FREQ_W]));

  // R3: an unqualified edge changes no output
  p_idle_edge_r3: assert property (@(posedge clk) disable iff (rst)
    ($past(!en || cs_n) && !$past(rst)) |->
      ($stable(sync_found) && $stable(timeout) && $stable(ctrl_valid) && $stable(ctrl_word)));
endmodule

bind cfg_preamble_detect cfg_preamble_detect_chk #(
  .CTRL_W   (CTRL_W),
  .FREQ_LSB (FREQ_LSB),
  .FREQ_W   (FREQ_W)
) i_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .cs_n       (cs_n),
  .sync_found (sync_found),
  .ctrl_valid (ctrl_valid),
  .ctrl_word  (ctrl_word),
  .freq_code  (freq_code),
  .timeout    (timeout)
);

// File: tb/test_cfg_preamble_detect.sv
`timescale 1ns/1ps
module test_cfg_preamble_detect;
  localparam int        LIMIT = 64;
  localparam logic [15:0] SYNC = 16'hBDB3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic        sync_found, ctrl_valid, timeout;
  logic [31:0] ctrl_word;
  logic [5:0]  freq_code;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  cfg_preamble_detect #(.TIMEOUT_BITS(LIMIT)) i_cfg_preamble_detect (
    .clk(clk), .rst(rst), .en(en), .cs_n(cs_n), .sdi(sdi),
    .sync_found(sync_found), .ctrl_valid(ctrl_valid), .ctrl_word(ctrl_word),
    .freq_code(freq_code), .timeout(timeout)
  );

  // reference model built from the requirements
  logic [15:0] m_win;
  logic [31:0] m_cap, m_word;
  int m_state, m_cnt, m_capn;
  logic m_sync, m_to, m_valid;

  task automatic model_reset();
    m_win = '0; m_cap = '0; m_word = '0; m_state = 0; m_cnt = 0; m_capn = 0;
    m_sync = 0; m_to = 0; m_valid = 0;
  endtask

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(sync_found == m_sync, "R2 sync_found", 32'(sync_found), 32'(m_sync));
    chk(timeout == m_to, "R6 timeout", 32'(timeout), 32'(m_to));
    chk(ctrl_valid == m_valid, "R4 ctrl_valid", 32'(ctrl_valid), 32'(m_valid));
    if (m_valid) begin
      chk(ctrl_word == m_word, "R4 ctrl_word", ctrl_word, m_word);
      chk(freq_code == m_word[21:16], "R5 freq_code", 32'(freq_code), 32'(m_word[21:16]));
    end
  endtask

  task automatic send_bit(input logic b, input logic e, input logic c);
    @(negedge clk);
    sdi = b; en = e; cs_n = c;
    @(posedge clk);
    #1;
    if (c) m_cnt = 0;
    if (e && !c) begin
      if (m_state == 0) begin
        m_win = {m_win[14:0], b};
        if (m_win == SYNC) begin m_sync = 1; m_state = 1; end
        else if (m_cnt == LIMIT - 1) begin m_to = 1; m_state = 3; end
        else m_cnt++;
      end else if (m_state == 1) begin
        m_cap = {m_cap[30:0], b};
        m_capn++;
        if (m_capn == 32) begin m_valid = 1; m_word = m_cap; m_state = 2; end
      end
    end
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; en = 0; cs_n = 1;
    @(posedge clk); #1;
    model_reset();
    chk(!sync_found && !timeout && !ctrl_valid && ctrl_word == 0 && freq_code == 0,
        "R1 reset outputs", {ctrl_word[27:0], sync_found, timeout, ctrl_valid, 1'b0}, 32'h0);
    @(negedge clk);
    rst = 0;
  endtask

  function automatic logic pad_bit(input int p, input int i);
    case (p)
      0: return 1'b0;
      1: return 1'b1;
      2: return logic'(i % 2);
      default: return logic'(((i * 7 + 3) >> 2) & 1);
    endcase
  endfunction

  // one real bit, with optional idle edges (R3) carrying opposite data
  task automatic send_real(input logic b, input bit gaps, input int i);
    if (gaps && (i % 3 == 0)) send_bit(~b, 1'b0, 1'b0);
    if (gaps && (i % 11 == 5)) send_bit(~b, 1'b1, 1'b1);
    send_bit(b, 1'b1, 1'b0);
  endtask

  task automatic send_word(input logic [31:0] w, input int n, input bit gaps);
    for (int k = n - 1; k >= 0; k--) send_real(w[k], gaps, k);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] w;
    model_reset();
    do_reset();

    // sweep filler content and length, sync, control word, trailing sync (R2 R4 R5 R6 R8 R3)
    for (int p = 0; p < 4; p++) begin
      for (int len = 0; len <= 70; len++) begin
        do_reset();
        for (int i = 0; i < len; i++) send_real(pad_bit(p, i), p == 3, i);
        send_word({16'h0, SYNC}, 16, p == 3);
        w = 32'hA5C3_1E0F ^ (32'(len) * 32'h0101_0101) ^ (32'(p) << 18);
        send_word(w, 32, p == 3);
        send_word({16'h0, SYNC}, 16, 1'b0);
        send_word(~w, 32, 1'b0);
      end
    end

    // R3: idle edges with sync data on the line leave everything unchanged
    do_reset();
    for (int k = 15; k >= 0; k--) send_bit(SYNC[k], 1'b0, 1'b0);
    for (int k = 15; k >= 0; k--) send_bit(SYNC[k], 1'b1, 1'b1);
    chk(!sync_found, "R3 unqualified bits ignored", 32'(sync_found), 32'd0);

    // R7: chip select restarts the count
    do_reset();
    for (int i = 0; i < LIMIT - 4; i++) send_bit(1'b0, 1'b1, 1'b0);
    send_bit(1'b0, 1'b1, 1'b1);
    for (int i = 0; i < LIMIT - 1; i++) send_bit(1'b0, 1'b1, 1'b0);
    chk(!timeout, "R7 count restarted", 32'(timeout), 32'd0);
    send_bit(1'b0, 1'b1, 1'b0);
    chk(timeout, "R7 timeout after full window", 32'(timeout), 32'd1);
    // R6: pattern after timeout is ignored
    send_word({16'h0, SYNC}, 16, 1'b0);
    chk(!sync_found && timeout, "R6 no sync after timeout", {30'h0, sync_found, timeout}, 32'd1);

    // R6: match completing on the LIMIT-th bit counts as found
    do_reset();
    for (int i = 0; i < LIMIT - 16; i++) send_bit(1'b0, 1'b1, 1'b0);
    send_word({16'h0, SYNC}, 16, 1'b0);
    chk(sync_found && !timeout, "R6 match on last bit wins", {30'h0, sync_found, timeout}, 32'd2);

    // R9: reset in the middle of a capture, then hunt afresh
    send_word(32'h1234_5678, 20, 1'b0);
    do_reset();
    send_word({16'h0, SYNC}, 16, 1'b0);
    send_word(32'h003F_0000, 32, 1'b0);
    chk(ctrl_valid && ctrl_word == 32'h003F_0000, "R9 fresh hunt after reset", ctrl_word, 32'h003F_0000);
    chk(freq_code == 6'h3F, "R5 all-ones field", 32'(freq_code), 32'h3F);
    // R8: further sync words ignored
    send_word({16'h0, SYNC}, 16, 1'b0);
    send_word(32'hFFFF_FFFF, 32, 1'b0);
    chk(ctrl_word == 32'h003F_0000, "R8 word held", ctrl_word, 32'h003F_0000);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule